// File: doc/BRIEF.md
# Converter Result Register with Atomic Byte-Pair Read

This block keeps the latest result of a 10-bit successive-approximation converter and shows it to software as two byte-wide read registers, a low byte and a high byte. A select input picks how the result sits across the two bytes: packed toward bit 0 (right aligned, the reset choice) or packed toward the top bit (left aligned). The alignment is applied to the stored value combinationally, so flipping the select changes both byte outputs at once without a new conversion.

To keep the two bytes from mixing two conversions, a read of the low byte freezes the stored value, and the matching read of the high byte unfreezes it. A conversion that finishes while frozen is dropped. Its completion flag is still raised, so software learns that a result came and went. The flag stays set until software writes one to its clear input. In left-aligned use, software that needs only eight bits can read just the high byte. That read leaves nothing frozen.

Top module: `adc_result_lock`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, both byte outputs read zero and `irq_flag` is low. No lock is held after reset.
- R2: With `left_align` low, `data_hi` is six zero bits above result bits 9..8, and `data_lo` is result bits 7..0.
- R3: With `left_align` high, `data_hi` is result bits 9..2, and `data_lo` is result bits 1..0 in bit positions 7..6, with zeros in bits 5..0.
- R4: A change of `left_align` alone changes both byte outputs in the same cycle. The stored result does not change.
- R5: A `conv_done` pulse is captured when no lock is held and `rd_lo` is low in that cycle. The new value shows on the outputs from the next cycle.
- R6: A `rd_lo` pulse sets the lock. A completion in the same cycle as that pulse, or while the lock is held, leaves both bytes unchanged. This includes a completion in the same cycle as the releasing `rd_hi`.
- R7: A `rd_hi` pulse releases the lock, so a completion on the next cycle is captured. If `rd_lo` and `rd_hi` are high in the same cycle, the lock ends released.
- R8: `irq_flag` is high on the cycle after every `conv_done` pulse, whether that result was captured or dropped.
- R9: A `flag_clr` pulse with no completion in that cycle clears `irq_flag` on the next cycle. If a completion arrives in the same cycle, the flag stays set.
- R10: A `rd_hi` pulse with no earlier `rd_lo` leaves no lock, so the next completion is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | One-cycle strobe marking that a conversion has finished |
| conv_data | input | 10 | Result that goes with `conv_done` |
| left_align | input | 1 | 0 packs the result toward bit 0; 1 packs it toward the top bit |
| rd_lo | input | 1 | Strobe for a software read of the low byte |
| rd_hi | input | 1 | Strobe for a software read of the high byte |
| flag_clr | input | 1 | Strobe for a software write of one to the completion flag |
| data_lo | output | 8 | Low byte view of the stored result |
| data_hi | output | 8 | High byte view of the stored result |
| irq_flag | output | 1 | Conversion-complete flag |

## Verification
Stored-value, lock and flag effects are registered. They are due one clock after the strobe that causes them, so the bench drives every strobe on a falling edge, drops it at the next falling edge and samples there, after exactly one rising edge. Alignment is the only zero-cycle path. The bench changes `left_align` between edges and samples a nanosecond later, with no edge in between. All 1024 result codes are swept through both alignments, and the lock cases check the stored value at the ports after each drop attempt and before any later capture.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    PAIR_OPEN   = 1'b0,
    PAIR_FROZEN = 1'b1
  } pair_state_e;
endpackage

// File: rtl/adc_res_store.sv
module adc_res_store
  import adc_res_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [RES_W-1:0] val_q,
  output logic             lock_q
);
  pair_state_e state_q, state_d;
  logic        accept;

  // A completion is dropped if the pair is frozen or is being frozen now
  assign accept = conv_done && (state_q == PAIR_OPEN) && !rd_lo;

  always_comb begin
    state_d = state_q;
    if (rd_hi)      state_d = PAIR_OPEN;
    else if (rd_lo) state_d = PAIR_FROZEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PAIR_OPEN;
      val_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) val_q <= conv_data;
    end
  end

  assign lock_q = (state_q == PAIR_FROZEN);
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align
  import adc_res_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic [RES_W-1:0]  val,
  input  logic              left_align,
  output logic [BYTE_W-1:0] byte_lo,
  output logic [BYTE_W-1:0] byte_hi
);
  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W == 0) begin : g_full
      assign pair = val;
    end else begin : g_pad
      assign pair = left_align ? {val, {PAD_W{1'b0}}}
                               : {{PAD_W{1'b0}}, val};
    end
  endgenerate

  assign byte_hi = pair[PAIR_W-1:BYTE_W];
  assign byte_lo = pair[BYTE_W-1:0];
endmodule

// File: rtl/adc_res_flag.sv
module adc_res_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
  import adc_res_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              left_align,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] data_lo,
  output logic [BYTE_W-1:0] data_hi,
  output logic              irq_flag
);
  logic [RES_W-1:0] val_q;
  logic             lock_q;

  adc_res_store #(.RES_W(RES_W)) store_i (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .val_q     (val_q),
    .lock_q    (lock_q)
  );

  adc_res_align #(.RES_W(RES_W)) align_i (
    .val        (val_q),
    .left_align (left_align),
    .byte_lo    (data_lo),
    .byte_hi    (data_hi)
  );

  adc_res_flag flag_i (
    .clk    (clk),
    .rst    (rst),
    .set_i  (conv_done),
    .clr_i  (flag_clr),
    .flag_q (irq_flag)
  );
endmodule

// File: rtl/adc_result_lock_chk.sv
module adc_result_lock_chk
  import adc_res_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              left_align,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic              flag_clr,
  input logic [BYTE_W-1:0] data_lo,
  input logic [BYTE_W-1:0] data_hi,
  input logic              irq_flag,
  input logic [RES_W-1:0]  val_q,
  input logic              lock_q
);
  localparam int unsigned PAD_W = 2 * BYTE_W - RES_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!irq_flag && !lock_q && val_q == '0));

  // R2
  right_pad_chk: assert property (@(posedge clk) disable iff (rst)
    !left_align |-> data_hi[BYTE_W-1:RES_W-BYTE_W] == '0);

  // R3
  left_pad_chk: assert property (@(posedge clk) disable iff (rst)
    left_align |-> data_lo[PAD_W-1:0] == '0);

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !lock_q && !rd_lo) |=> val_q == $past(conv_data));

  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q || rd_lo) |=> $stable(val_q));

  // R6
  freeze_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> lock_q);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> !lock_q);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> irq_flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !conv_done) |=> !irq_flag);
endmodule

bind adc_result_lock adc_result_lock_chk #(.RES_W(RES_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .conv_done  (conv_done),
  .conv_data  (conv_data),
  .left_align (left_align),
  .rd_lo      (rd_lo),
  .rd_hi      (rd_hi),
  .flag_clr   (flag_clr),
  .data_lo    (data_lo),
  .data_hi    (data_hi),
  .irq_flag   (irq_flag),
  .val_q      (val_q),
  .lock_q     (lock_q)
);

// File: tb/adc_result_lock_tb_top.sv
module adc_result_lock_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       left_align = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] data_lo, data_hi;
  logic       irq_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_result_lock dut_i (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
    .left_align(left_align), .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr),
    .data_lo(data_lo), .data_hi(data_hi), .irq_flag(irq_flag)
  );

  function automatic logic [7:0] want_hi(int v, bit la);
    return la ? 8'((v / 4) % 256) : 8'(v / 256);
  endfunction

  function automatic logic [7:0] want_lo(int v, bit la);
    return la ? 8'((v % 4) * 64) : 8'(v % 256);
  endfunction

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_val(string req, int v);
    chk(req, int'(data_hi), int'(want_hi(v, left_align)));
    chk(req, int'(data_lo), int'(want_lo(v, left_align)));
  endtask

  // Called at a falling edge: drive for one rising edge, sample at the next falling edge
  task automatic pulse(bit d, int v, bit lo, bit hi, bit clr);
    conv_done = d; conv_data = 10'(v); rd_lo = lo; rd_hi = hi; flag_clr = clr;
    @(negedge clk);
    conv_done = 0; rd_lo = 0; rd_hi = 0; flag_clr = 0;
  endtask

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'({data_hi, data_lo, irq_flag}), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", int'({data_hi, data_lo, irq_flag}), 0);
    pulse(1, 10'h1A5, 0, 0, 0);   // R1: no lock left by reset
    cur = 10'h1A5;
    chk_val("R1 open after reset", cur);

    // R2 R3 R4 R5: sweep all codes, both alignments
    for (int v = 0; v < 1024; v++) begin
      left_align = 0;
      pulse(1, v, 0, 0, 0);
      chk_val("R5 R2 right", v);
      #1 left_align = 1;
      #1 chk_val("R4 R3 left", v);
      #1 left_align = 0;
      #1 chk_val("R4 R2 back", v);
      @(negedge clk);
    end
    cur = 1023;
    chk("R8 flag after sweep", int'(irq_flag), 1);
    pulse(0, 0, 0, 0, 1);
    chk("R9 clear", int'(irq_flag), 0);

    // R6: frozen pair drops completions
    pulse(1, 10'h2A5, 0, 0, 0); cur = 10'h2A5;
    pulse(0, 0, 0, 0, 1);
    pulse(0, 0, 1, 0, 0);
    pulse(1, 10'h111, 0, 0, 0);
    chk_val("R6 dropped while frozen", cur);
    chk("R8 flag on dropped", int'(irq_flag), 1);
    pulse(1, 10'h0F0, 0, 1, 0);
    chk_val("R6 dropped with release", cur);
    pulse(1, 10'h3C3, 0, 0, 0); cur = 10'h3C3;
    chk_val("R7 captured after release", cur);

    // R6: completion in the same cycle as the freezing read
    pulse(1, 10'h0AA, 1, 0, 0);
    chk_val("R6 dropped on freeze cycle", cur);
    pulse(0, 0, 0, 1, 0);
    pulse(1, 10'h155, 0, 0, 0); cur = 10'h155;
    chk_val("R7 release", cur);

    // R7: both reads in one cycle leave it released
    pulse(0, 0, 1, 1, 0);
    pulse(1, 10'h2DB, 0, 0, 0); cur = 10'h2DB;
    chk_val("R7 both reads", cur);

    // R10: high byte only, left aligned
    left_align = 1;
    pulse(0, 0, 0, 1, 0);
    chk_val("R10 hi read", cur);
    pulse(1, 10'h2AA, 0, 0, 0); cur = 10'h2AA;
    chk_val("R10 no lock", cur);
    left_align = 0;

    // R9: set beats clear
    pulse(0, 0, 0, 0, 1);
    chk("R9 clear", int'(irq_flag), 0);
    pulse(1, 10'h001, 0, 0, 1); cur = 1;
    chk("R9 set wins", int'(irq_flag), 1);
    chk_val("R5 capture with clear", cur);
    pulse(0, 0, 0, 0, 0);
    chk("R8 flag held", int'(irq_flag), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule